// File: doc/BRIEF.md
# Runt Pulse Detector

This block watches one stream of digitized samples and reports runt pulses. A runt is an excursion that leaves its starting region, passes into the band between a lower and an upper threshold, and then goes back to where it started without reaching the far threshold. Swings that cross both thresholds are full transitions and never fire the trigger.

Each strobed sample is sorted into one of three regions: low, middle or high. A small state machine follows the signal between these regions. A counter measures how many samples the signal spends in the middle band. A runt fires only if its middle-band dwell reaches a programmed minimum and its direction matches the polarity select. When a runt fires, the block gives a one-cycle trigger pulse and reports the dwell length. Acquisition equipment uses this to stop on marginal logic levels caused by reflections or weak drivers.

Top module: `runt_detector`

## Requirements
- R1: A sample at or below `thr_lo_i` is in the low region. A sample at or above `thr_hi_i` is in the high region. A sample strictly between them is in the middle band. A sample equal to either threshold therefore counts as having reached it.
- R2: A positive runt fires the trigger. It starts in the low region, enters the middle band and returns to the low region.
- R3: A negative runt fires the trigger. It starts in the high region, enters the middle band and returns to the high region.
- R4: A full transition never fires the trigger. This covers a move from low to high or from high to low, whether direct or through the middle band.
- R5: A runt fires only if its number of middle-band samples is at least `min_width_i`. A value of 0 accepts every runt.
- R6: `pol_sel_i` selects which runts may fire. 2'b00 allows positive runts only, 2'b01 allows negative runts only, and 2'b10 or 2'b11 allows both.
- R7: `trig_o` is high for exactly one cycle. That cycle directly follows the clock edge that accepts the returning sample.
- R8: `runt_len_o` is loaded with the middle-band sample count of each runt that fires, and otherwise holds its value.
- R9: The middle-band count saturates at 2^CNT_W-1.
- R10: After reset the region is unknown. Middle-band samples are ignored until a sample is first seen in the low or high region.
- R11: While `arm_i` is low, samples are ignored and no trigger fires. The tracked region returns to unknown, so after re-arming a fresh low or high sample is needed before any runt can fire.
- R12: A cycle with `sample_vld_i` low has no effect on the detector.
- R13: During and after reset, `trig_o` and `runt_len_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Enables detection; when low, the detector stays idle |
| sample_vld_i | input | 1 | Strobe marking a valid sample |
| sample_i | input | SAMPLE_W | Unsigned sample value |
| thr_lo_i | input | SAMPLE_W | Lower threshold |
| thr_hi_i | input | SAMPLE_W | Upper threshold |
| pol_sel_i | input | 2 | Polarity select (see R6) |
| min_width_i | input | CNT_W | Minimum middle-band dwell in samples |
| trig_o | output | 1 | One-cycle runt trigger |
| runt_len_o | output | CNT_W | Middle-band dwell of the last runt that fired |

## Verification
The assertions assume that `thr_lo_i` is below `thr_hi_i` and that both thresholds stay fixed while a pulse is in progress. They also assume that `min_width_i` is the value meant for the sample that completes a runt. The stimulus holds the thresholds at 80 and 200 for the whole run. It changes polarity and minimum width only while the signal rests at a baseline level. Under those conditions the bench sweeps peak level, dwell length, minimum width and polarity, with boundary peaks placed on and beside each threshold.

// File: rtl/runt_pkg.sv
package runt_pkg;
  typedef enum logic [1:0] {
    REG_LO  = 2'd0,
    REG_MID = 2'd1,
    REG_HI  = 2'd2
  } region_e;

  typedef enum logic [2:0] {
    ST_UNKNOWN  = 3'd0,
    ST_LOW      = 3'd1,
    ST_HIGH     = 3'd2,
    ST_RISE_MID = 3'd3,
    ST_FALL_MID = 3'd4
  } det_state_e;
endpackage

// File: rtl/runt_level_cmp.sv
module runt_level_cmp
  import runt_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] thr_lo_i,
  input  logic [SAMPLE_W-1:0] thr_hi_i,
  output region_e             region_o
);
  // reaching a threshold counts as crossing it
  always_comb begin
    if (sample_i <= thr_lo_i)      region_o = REG_LO;
    else if (sample_i >= thr_hi_i) region_o = REG_HI;
    else                           region_o = REG_MID;
  end
endmodule

// File: rtl/runt_dwell_ctr.sv
module runt_dwell_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_one_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CntOne = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_one_i)               cnt_q <= CntOne;
    else if (inc_i && cnt_q != CntMax) cnt_q <= cnt_q + CntOne;
  end

  assign cnt_o = cnt_q;

  assert_cnt_saturate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CntMax && inc_i && !load_one_i) |=> (cnt_q == CntMax));

  assert_cnt_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_one_i |=> (cnt_q == CntOne));
endmodule

// File: rtl/runt_fsm.sv
module runt_fsm
  import runt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             vld_i,
  input  region_e          region_i,
  input  logic [1:0]       pol_sel_i,
  input  logic [CNT_W-1:0] min_width_i,
  input  logic [CNT_W-1:0] dwell_i,
  output logic             dwell_load_o,
  output logic             dwell_inc_o,
  output logic             trig_o,
  output logic [CNT_W-1:0] runt_len_o
);
  det_state_e state_q, state_d;
  logic fire, pos_ok, neg_ok, wide_ok;
  logic trig_q;
  logic [CNT_W-1:0] len_q;

  assign pos_ok  = (pol_sel_i != 2'b01);
  assign neg_ok  = (pol_sel_i != 2'b00);
  assign wide_ok = (dwell_i >= min_width_i);

  always_comb begin
    state_d      = state_q;
    dwell_load_o = 1'b0;
    dwell_inc_o  = 1'b0;
    fire         = 1'b0;
    if (!arm_i) begin
      state_d = ST_UNKNOWN;
    end else if (vld_i) begin
      case (state_q)
        ST_UNKNOWN: begin
          if (region_i == REG_LO)      state_d = ST_LOW;
          else if (region_i == REG_HI) state_d = ST_HIGH;
        end
        ST_LOW: begin
          if (region_i == REG_MID) begin
            state_d      = ST_RISE_MID;
            dwell_load_o = 1'b1;
          end else if (region_i == REG_HI) state_d = ST_HIGH;
        end
        ST_HIGH: begin
          if (region_i == REG_MID) begin
            state_d      = ST_FALL_MID;
            dwell_load_o = 1'b1;
          end else if (region_i == REG_LO) state_d = ST_LOW;
        end
        ST_RISE_MID: begin
          if (region_i == REG_MID) dwell_inc_o = 1'b1;
          else if (region_i == REG_LO) begin
            state_d = ST_LOW;
            fire    = pos_ok && wide_ok;
          end else state_d = ST_HIGH;
        end
        ST_FALL_MID: begin
          if (region_i == REG_MID) dwell_inc_o = 1'b1;
          else if (region_i == REG_HI) begin
            state_d = ST_HIGH;
            fire    = neg_ok && wide_ok;
          end else state_d = ST_LOW;
        end
        default: state_d = ST_UNKNOWN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_UNKNOWN;
      trig_q  <= 1'b0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      trig_q  <= fire;
      if (fire) len_q <= dwell_i;
    end
  end

  assign trig_o     = trig_q;
  assign runt_len_o = len_q;

  assert_trig_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  assert_disarm_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (!trig_o && state_q == ST_UNKNOWN));

  assert_no_strobe_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && arm_i) |=> (!trig_o && $stable(state_q)));

  assert_min_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (runt_len_o >= $past(min_width_i) && runt_len_o != '0));

  assert_len_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_o |-> $stable(runt_len_o));

  assert_unknown_mid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UNKNOWN && region_i == REG_MID) |=> (state_q == ST_UNKNOWN));
endmodule

// File: rtl/runt_detector.sv
module runt_detector
  import runt_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int CNT_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                arm_i,
  input  logic                sample_vld_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] thr_lo_i,
  input  logic [SAMPLE_W-1:0] thr_hi_i,
  input  logic [1:0]          pol_sel_i,
  input  logic [CNT_W-1:0]    min_width_i,
  output logic                trig_o,
  output logic [CNT_W-1:0]    runt_len_o
);
  region_e          region;
  logic             dwell_load, dwell_inc;
  logic [CNT_W-1:0] dwell;

  runt_level_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
    .sample_i (sample_i),
    .thr_lo_i (thr_lo_i),
    .thr_hi_i (thr_hi_i),
    .region_o (region)
  );

  runt_dwell_ctr #(.CNT_W(CNT_W)) u_dwell (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_one_i (dwell_load),
    .inc_i      (dwell_inc),
    .cnt_o      (dwell)
  );

  runt_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arm_i        (arm_i),
    .vld_i        (sample_vld_i),
    .region_i     (region),
    .pol_sel_i    (pol_sel_i),
    .min_width_i  (min_width_i),
    .dwell_i      (dwell),
    .dwell_load_o (dwell_load),
    .dwell_inc_o  (dwell_inc),
    .trig_o       (trig_o),
    .runt_len_o   (runt_len_o)
  );

  assert_reset_quiet_R13: assert property (@(posedge clk_i)
    !rst_ni |-> (!trig_o && runt_len_o == '0));
endmodule

// File: tb/tb_runt_detector.sv
`timescale 1ns/1ps
module tb_runt_detector;
  localparam int SW = 8;
  localparam int CW = 8;
  localparam int LO = 80;
  localparam int HI = 200;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          arm_i = 1'b0;
  logic          sample_vld_i = 1'b0;
  logic [SW-1:0] sample_i = '0;
  logic [SW-1:0] thr_lo_i = SW'(LO);
  logic [SW-1:0] thr_hi_i = SW'(HI);
  logic [1:0]    pol_sel_i = 2'b00;
  logic [CW-1:0] min_width_i = '0;
  logic          trig_o;
  logic [CW-1:0] runt_len_o;

  int checks = 0;
  int errors = 0;
  int tcnt   = 0;

  always #10 clk = ~clk;

  runt_detector #(.SAMPLE_W(SW), .CNT_W(CW)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .arm_i        (arm_i),
    .sample_vld_i (sample_vld_i),
    .sample_i     (sample_i),
    .thr_lo_i     (thr_lo_i),
    .thr_hi_i     (thr_hi_i),
    .pol_sel_i    (pol_sel_i),
    .min_width_i  (min_width_i),
    .trig_o       (trig_o),
    .runt_len_o   (runt_len_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one strobed sample; returns at the negedge after the accepting edge
  task automatic send(input int s);
    @(negedge clk);
    sample_i     = SW'(s);
    sample_vld_i = 1'b1;
    @(negedge clk);
    sample_vld_i = 1'b0;
    if (trig_o) tcnt++;
  endtask

  task automatic pulse(input int base, input int peak, input int w);
    send(base);
    for (int i = 0; i < w; i++) send(peak);
    send(base);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(trig_o == 1'b0 && runt_len_o == '0, "R13 reset", int'(runt_len_o), 0);
    rst_ni = 1'b1;
    arm_i  = 1'b1;

    // R10: mid samples before any region acquisition
    tcnt = 0; pol_sel_i = 2'b10; min_width_i = '0;
    send(120); send(10);
    chk(tcnt == 0, "R10 unknown start", tcnt, 0);
    tcnt = 0; send(120); send(10);
    chk(tcnt == 1, "R10 acquired then runt", tcnt, 1);
    chk(runt_len_o == 1, "R8 len", int'(runt_len_o), 1);

    // R7: pulse ends after one cycle
    @(negedge clk);
    chk(trig_o == 1'b0, "R7 single cycle", int'(trig_o), 0);

    // R1 R2 R3 R4 R5 R6 sweep
    for (int pol = 0; pol < 3; pol++) begin
      for (int dir = 0; dir < 2; dir++) begin
        for (int p = 0; p < 256; p++) begin
          if (!((p % 5) == 0 || (p >= LO-1 && p <= LO+1) || (p >= HI-1 && p <= HI+1))) continue;
          for (int w = 1; w <= 3; w++) begin
            for (int mw = 0; mw <= 3; mw++) begin
              int  base;
              logic pol_ok, exp_t;
              if (mw == 1) continue;
              base = (dir == 0) ? 10 : 240;
              pol_sel_i   = 2'(pol);
              min_width_i = CW'(mw);
              pol_ok = (pol == 2) || (pol == 0 && dir == 0) || (pol == 1 && dir == 1);
              exp_t  = (p > LO) && (p < HI) && (w >= mw) && pol_ok;
              tcnt = 0;
              pulse(base, p, w);
              if (dir == 0)
                chk(tcnt == int'(exp_t), "R1 R2 R4 R5 R6 positive sweep", tcnt, int'(exp_t));
              else
                chk(tcnt == int'(exp_t), "R1 R3 R4 R5 R6 negative sweep", tcnt, int'(exp_t));
              if (exp_t) chk(runt_len_o == CW'(w), "R8 sweep len", int'(runt_len_o), w);
            end
          end
        end
      end
    end

    // R4: full swing through mid band both ways
    pol_sel_i = 2'b10; min_width_i = '0; tcnt = 0;
    send(10); send(120); send(240); send(120); send(10);
    chk(tcnt == 0, "R4 full swing via mid", tcnt, 0);

    // R12: unstrobed samples ignored
    send(10); send(150);
    @(negedge clk); sample_i = 8'd250;
    repeat (4) @(negedge clk);
    tcnt = 0; send(10);
    chk(tcnt == 1, "R12 unstrobed ignored", tcnt, 1);
    chk(runt_len_o == 1, "R12 len", int'(runt_len_o), 1);

    // R11: disarm mid-pulse, then samples while disarmed
    send(10); send(120);
    @(negedge clk); arm_i = 1'b0;
    tcnt = 0;
    send(10); send(120); send(10);
    chk(tcnt == 0, "R11 disarmed", tcnt, 0);
    chk(runt_len_o == 1, "R11 len held", int'(runt_len_o), 1);
    @(negedge clk); arm_i = 1'b1;
    send(120); send(10);
    chk(tcnt == 0, "R11 reacquire needed", tcnt, 0);
    send(120); send(120); send(10);
    chk(tcnt == 1, "R11 rearmed runt", tcnt, 1);
    chk(runt_len_o == 2, "R11 len", int'(runt_len_o), 2);

    // R9: saturation
    tcnt = 0; send(240);
    for (int i = 0; i < 300; i++) send(150);
    send(240);
    chk(tcnt == 1, "R9 long runt fires", tcnt, 1);
    chk(runt_len_o == 255, "R9 saturate", int'(runt_len_o), 255);

    // R5: min at maximum
    min_width_i = 8'd255; tcnt = 0;
    send(240);
    for (int i = 0; i < 254; i++) send(150);
    send(240);
    chk(tcnt == 0, "R5 short of max min", tcnt, 0);

    // R13: reset clears outputs
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk(trig_o == 1'b0 && runt_len_o == '0, "R13 re-reset", int'(runt_len_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule